// File: doc/BRIEF.md
# USB Link Status LED Controller

This block turns a handful of device-state signals into the drive for one active-low status lamp that reports the health of a USB link. The lamp is dark out of reset and while the device has not been configured. Each bus-traffic pulse seen during enumeration lights it briefly. Once the configured flag is high, the lamp stays lit. Each acknowledged transfer then darkens it briefly. Suspend forces the lamp dark and overrides every other input.

The polarity of a blink depends on state. Before configuration a blink is a short flash on a dark lamp. After configuration it is a short gap in a lit lamp. The blink length is set by a parameter. A new qualifying event during a blink restarts the full blink length. Entering suspend or changing the configured flag cancels any blink in progress. The lamp then shows the plain level for the new state.

Top module: `link_led_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `led_n_o` is 1 (dark). The device is treated as unconfigured until `cfg_i` is sampled high.
- R2: When unconfigured, not suspended and with no blink running, `led_n_o` is 1.
- R3: When unconfigured and not suspended, an `enum_evt_i` pulse sampled at a clock edge drives `led_n_o` to 0 from that edge. It stays 0 for exactly BLINK_CYCLES cycles and then returns to 1.
- R4: One cycle after `cfg_i` is sampled high, with no suspend, `led_n_o` is 0 (lit) and stays 0 while idle.
- R5: When configured and not suspended, an `ack_evt_i` pulse drives `led_n_o` to 1 for exactly BLINK_CYCLES cycles from the sampling edge. The lamp then returns to 0.
- R6: A qualifying event sampled during a blink restarts the blink. The blink ends BLINK_CYCLES cycles after the latest event.
- R7: `ack_evt_i` has no effect while unconfigured. `enum_evt_i` has no effect while configured.
- R8: From the edge that samples `susp_i` high, `led_n_o` is 1. Events sampled while `susp_i` is high are ignored.
- R9: `susp_i` sampled high cancels any running blink. On the first edge with `susp_i` low, the lamp returns to the idle level set by the configured state.
- R10: A change of `cfg_i` cancels any running blink. The lamp then shows the idle level of the new state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enum_evt_i | input | 1 | One-cycle pulse: bus traffic during enumeration |
| ack_evt_i | input | 1 | One-cycle pulse: transfer completed with acknowledge |
| cfg_i | input | 1 | Device is configured (level) |
| susp_i | input | 1 | Device is suspended (level) |
| led_n_o | output | 1 | Lamp drive, 0 = lit |

## Verification
The hardest states to reach are the ones where a blink is running and the device state changes underneath it. Examples are the configured flag toggling halfway through a flash, or suspend arriving together with an acknowledge pulse. The stimulus table starts a blink and changes `cfg_i` or `susp_i` on the very next cycle. A blink that was not cancelled would show the wrong lamp level at that point. A second event placed two cycles into a blink separates a restarted timer from one that merely keeps running.

// File: rtl/link_led_pkg.sv
package link_led_pkg;

    typedef enum logic [1:0] {
        LM_UNCFG = 2'd0,
        LM_CFG   = 2'd1,
        LM_SUSP  = 2'd2
    } link_mode_e;

    typedef struct packed {
        logic enum_evt;
        logic ack_evt;
    } link_evt_t;

    function automatic int blink_cnt_w(input int cycles);
        return $clog2(cycles + 1);
    endfunction

    // Lamp is lit when: configured and no gap, or unconfigured and flashing.
    function automatic logic lamp_lit(input link_mode_e mode, input logic blinking);
        case (mode)
            LM_UNCFG: return blinking;
            LM_CFG:   return !blinking;
            default:  return 1'b0;
        endcase
    endfunction

    // Picks the event that is meaningful in the current configured state.
    function automatic logic pick_event(input link_evt_t ev, input logic configured);
        return configured ? ev.ack_evt : ev.enum_evt;
    endfunction

endpackage

// File: rtl/link_mode_track.sv
module link_mode_track
    import link_led_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_i,
    input  logic       susp_i,
    output link_mode_e mode_o,
    output logic       cfg_q_o,
    output logic       cfg_flip_o
);

    logic cfg_q;
    logic susp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            cfg_q  <= cfg_i;
            susp_q <= susp_i;
        end
    end

    always_comb begin
        if (susp_q)     mode_o = LM_SUSP;
        else if (cfg_q) mode_o = LM_CFG;
        else            mode_o = LM_UNCFG;
    end

    assign cfg_q_o    = cfg_q;
    assign cfg_flip_o = cfg_i ^ cfg_q;

    AST_RESET_UNCFG: assert property (@(posedge clk)
        rst |=> (mode_o == LM_UNCFG)); // R1

endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
    parameter int BLINK_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic cancel_i,
    output logic busy_o
);

    localparam int CW = link_led_pkg::blink_cnt_w(BLINK_CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(BLINK_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cancel_i)  cnt <= '0;
        else if (trig_i)      cnt <= LOAD_VAL;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD_VAL); // R6

    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        cancel_i |=> !busy_o); // R9

endmodule

// File: rtl/led_driver.sv
module led_driver
    import link_led_pkg::*;
(
    input  link_mode_e mode_i,
    input  logic       busy_i,
    output logic       led_n_o
);

    always_comb begin
        led_n_o = !lamp_lit(mode_i, busy_i);
    end

endmodule

// File: rtl/link_led_ctrl.sv
module link_led_ctrl
    import link_led_pkg::*;
#(
    parameter int BLINK_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic enum_evt_i,
    input  logic ack_evt_i,
    input  logic cfg_i,
    input  logic susp_i,
    output logic led_n_o
);

    link_mode_e mode;
    logic       cfg_q;
    logic       cfg_flip;
    logic       busy;
    logic       trig;
    logic       cancel;
    link_evt_t  ev;

    assign ev.enum_evt = enum_evt_i;
    assign ev.ack_evt  = ack_evt_i;

    link_mode_track u_mode (
        .clk        (clk),
        .rst        (rst),
        .cfg_i      (cfg_i),
        .susp_i     (susp_i),
        .mode_o     (mode),
        .cfg_q_o    (cfg_q),
        .cfg_flip_o (cfg_flip)
    );

    // Suspend and a change of configuration both win over a new event.
    assign cancel = susp_i | cfg_flip;
    assign trig   = pick_event(ev, cfg_q);

    blink_timer #(
        .BLINK_CYCLES(BLINK_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (trig),
        .cancel_i (cancel),
        .busy_o   (busy)
    );

    led_driver u_drv (
        .mode_i  (mode),
        .busy_i  (busy),
        .led_n_o (led_n_o)
    );

    AST_UNCFG_FLASH: assert property (@(posedge clk) disable iff (rst)
        (mode == LM_UNCFG && enum_evt_i && !cfg_i && !susp_i) |=> !led_n_o); // R3

    AST_CFG_GAP: assert property (@(posedge clk) disable iff (rst)
        (mode == LM_CFG && ack_evt_i && cfg_i && !susp_i) |=> led_n_o); // R5

    AST_SUSP_DARK: assert property (@(posedge clk) disable iff (rst)
        susp_i |=> led_n_o); // R8

    AST_CFG_IDLE_LIT: assert property (@(posedge clk) disable iff (rst)
        (cfg_i && !susp_i && !ack_evt_i && mode == LM_CFG && !busy) |=> !led_n_o); // R4

endmodule

// File: tb/sim_link_led_ctrl.sv
`timescale 1ns/1ps
module sim_link_led_ctrl;

    localparam int BLINK = 4;
    localparam int NVEC  = 35;

    logic clk = 1'b0;
    logic rst, enum_evt, ack_evt, cfg, susp;
    logic led_n;
    int   n_tests = 0;
    int   n_fail  = 0;
    logic done    = 1'b0;

    always #4 clk = ~clk;

    link_led_ctrl #(.BLINK_CYCLES(BLINK)) u0 (
        .clk        (clk),
        .rst        (rst),
        .enum_evt_i (enum_evt),
        .ack_evt_i  (ack_evt),
        .cfg_i      (cfg),
        .susp_i     (susp),
        .led_n_o    (led_n)
    );

    // {rst, enum, ack, cfg, susp, expected led_n after the sampling edge}
    localparam logic [5:0] VEC [0:NVEC-1] = '{
        6'b1_0_0_0_0_1, // 0  R1 reset
        6'b0_0_0_0_0_1, // 1  R2 idle dark
        6'b0_0_1_0_0_1, // 2  R7 ack ignored unconfigured
        6'b0_1_0_0_0_0, // 3  R3 flash starts
        6'b0_0_0_0_0_0, // 4
        6'b0_0_0_0_0_0, // 5
        6'b0_0_0_0_0_0, // 6
        6'b0_0_0_0_0_1, // 7  R3 flash ends after BLINK
        6'b0_1_0_0_0_0, // 8
        6'b0_0_0_0_0_0, // 9
        6'b0_1_0_0_0_0, // 10 R6 restart
        6'b0_0_0_0_0_0, // 11
        6'b0_0_0_0_0_0, // 12 R6 still lit
        6'b0_0_0_0_0_0, // 13
        6'b0_0_0_0_0_1, // 14
        6'b0_0_0_1_0_0, // 15 R4 configured lit
        6'b0_0_1_1_0_1, // 16 R5 gap starts
        6'b0_0_0_1_0_1, // 17
        6'b0_0_0_1_0_1, // 18
        6'b0_0_0_1_0_1, // 19
        6'b0_0_0_1_0_0, // 20 R5 gap ends
        6'b0_1_0_1_0_0, // 21 R7 enum ignored configured
        6'b0_0_1_1_0_1, // 22
        6'b0_0_0_1_1_1, // 23 R8 suspend dark
        6'b0_1_1_1_1_1, // 24 R8 events ignored
        6'b0_0_0_1_0_0, // 25 R9 resume lit, no gap
        6'b0_0_1_1_0_1, // 26
        6'b0_0_0_0_0_1, // 27 R10 cfg fall cancels gap
        6'b0_1_0_0_0_0, // 28
        6'b0_0_0_1_0_0, // 29 R10 cfg rise cancels flash
        6'b0_0_0_1_0_0, // 30
        6'b0_0_1_1_1_1, // 31 R8 ack with suspend
        6'b0_0_0_1_0_0, // 32 R9 resume lit
        6'b1_0_0_1_0_1, // 33 R1 reset while configured
        6'b0_0_0_0_0_1  // 34 R1 unconfigured after reset
    };

    task automatic check(input logic exp, input string tag);
        n_tests++;
        if (led_n !== exp) begin
            n_fail++;
            $display("FAIL %s: led_n_o=%b expected %b", tag, led_n, exp);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic a,
                        input logic c, input logic s);
        @(negedge clk);
        rst = r; enum_evt = e; ack_evt = a; cfg = c; susp = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; enum_evt = 1'b0; ack_evt = 1'b0; cfg = 1'b0; susp = 1'b0;
        step(1, 0, 0, 0, 0);
        check(1'b1, "R1 reset dark");

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            check(VEC[i][0], $sformatf("vector %0d (R1-R10 table)", i));
        end

        // R1: reset in the middle of a flash
        step(0, 1, 0, 0, 0);
        check(1'b0, "R3 flash before reset");
        step(1, 0, 0, 0, 0);
        check(1'b1, "R1 reset cancels flash");
        step(0, 0, 0, 0, 0);
        check(1'b1, "R1 dark after reset");

        // R5/R6: repeated acks keep the gap open
        step(0, 0, 0, 1, 0);
        check(1'b0, "R4 lit");
        for (int k = 0; k < 6; k++) begin
            step(0, 0, 1, 1, 0);
            check(1'b1, "R6 back-to-back acks");
        end
        for (int k = 0; k < BLINK - 1; k++) begin
            step(0, 0, 0, 1, 0);
            check(1'b1, "R5 gap held");
        end
        step(0, 0, 0, 1, 0);
        check(1'b0, "R5 gap over");

        // R8: suspend mid-gap, held several cycles with traffic
        step(0, 0, 1, 1, 0);
        for (int k = 0; k < 5; k++) begin
            step(0, 1, 1, 1, 1);
            check(1'b1, "R8 suspended dark");
        end
        step(0, 0, 0, 1, 0);
        check(1'b0, "R9 resume configured lit");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule